// File: doc/BRIEF.md
# Dithered Switching Period Generator

This block divides a system clock of roughly 7 MHz into the start pulses of a switching converter's periods. Two nominal divisions are available: 16 clocks (about 444 kHz) or 8 clocks (about 888 kHz). When spreading is switched on, the length of successive periods follows a triangular sweep. The sweep stays within one eighth of the nominal length above and below it, and it repeats after a fixed whole number of periods. The sweep is built so that the periods of each complete sweep add up to exactly the nominal length times the number of periods. The mean rate therefore never drifts.

An optional hopping mode alternates the nominal rate between the two settings, one complete sweep at a time, to spread the emission further. Outputs are free-running control signals with no handshake and no back-pressure. Each period is announced by a one-cycle pulse. Its length in clocks and a flag telling whether the sweep is in its ascending part are held for the whole period. The configuration pins are sampled only on the final clock of a period.

Top module: `dither_period_gen`

## Requirements
- R1: After reset is released, a period begins in the first clock cycle. It is 16 clocks long (low rate), and `dither_up_o` is 0.
- R2: `period_start_o` is high only in the first cycle of every period. `period_len_o` holds that period's length for the whole period, and it equals the number of cycles until the next start. With spreading and hopping off, every period is 16 clocks when `fast_sel_i`=0 and 8 clocks when `fast_sel_i`=1.
- R3: With spreading on, each period lies within the nominal length plus or minus one eighth: 14 to 18 clocks at the low rate, 7 to 9 at the high rate.
- R4: One sweep lasts 25 periods at the low rate and 50 periods at the high rate. The lengths over a complete sweep add up to exactly 400 clocks in both cases.
- R5: For sweep index p (0 at the first period of a sweep), with N the nominal length, M the sweep length, A = N/8 and peak P = A*M, let x = 4*A*p. The target offset V in units of 1/M clock is x for x <= P, 2P-x for x <= 3P, and x-4P otherwise. A carry c (0 <= c < M, cleared at each sweep restart) gives the period length N + floor((c+V)/M), and the remainder becomes the new carry. The first period of a sweep is therefore exactly N.
- R6: `dither_up_o` is 1 during a period with spreading on whose index satisfies x < P or x >= 3P. It is 0 otherwise, and always 0 with spreading off (13 of 25 periods at the low rate, 25 of 50 at the high rate).
- R7: A change of `fast_sel_i` or `dither_en_i` does not alter the period in progress. It applies from the next period, which restarts the sweep at index 0 with a cleared carry.
- R8: With `hop_en_i`=1, the rate toggles after each complete sweep, so the sweeps run as 50 high-rate periods, then 25 low-rate periods, and so on. `fast_sel_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_sel_i | input | 1 | 0 = divide by 16, 1 = divide by 8 |
| dither_en_i | input | 1 | Enables the triangular spreading |
| hop_en_i | input | 1 | Enables rate alternation per sweep |
| period_start_o | output | 1 | One-cycle pulse in the first cycle of a period |
| period_len_o | output | 5 | Length of the current period in clocks |
| dither_up_o | output | 1 | Sweep is in an ascending part |

## Verification
The configuration is taken on the last clock edge of a period. The start pulse, length and sweep flag of the next period all appear in the cycle right after that edge, so one period of latency applies to every setting change. The bench samples on falling edges and changes settings only at the falling edge where a start is seen, or at a chosen point inside a period. An independent reference built from the formula in R5 predicts each period's length and flag. Each prediction is compared when the pulse is seen, and the measured pulse spacing is compared with it one period later.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  typedef enum logic {
    RATE_LOW  = 1'b0,
    RATE_HIGH = 1'b1
  } rate_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dpg_rate_ctrl.sv
// Holds the active rate, spreading state and sweep index; computes their
// values for the next period, including hop and restart decisions.
module dpg_rate_ctrl
  import dpg_pkg::*;
#(
  parameter int CYC_LOW  = 25,
  parameter int CYC_HIGH = 50,
  parameter int PH_W     = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            boundary_i,
  input  logic            fast_sel_i,
  input  logic            dither_en_i,
  input  logic            hop_en_i,
  output rate_e           rate_nx_o,
  output logic            dith_nx_o,
  output logic [PH_W-1:0] phase_nx_o,
  output logic            restart_o
);
  rate_e           rate_q;
  logic            dith_q;
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] last_idx;
  logic            cyc_last;

  always_comb begin
    last_idx = (rate_q == RATE_HIGH) ? PH_W'(CYC_HIGH - 1) : PH_W'(CYC_LOW - 1);
    cyc_last = (phase_q == last_idx);
    if (hop_en_i) begin
      if (cyc_last) rate_nx_o = (rate_q == RATE_HIGH) ? RATE_LOW : RATE_HIGH;
      else          rate_nx_o = rate_q;
    end else begin
      rate_nx_o = fast_sel_i ? RATE_HIGH : RATE_LOW;
    end
    dith_nx_o  = dither_en_i;
    restart_o  = (rate_nx_o != rate_q) || (dith_nx_o != dith_q);
    phase_nx_o = (restart_o || cyc_last) ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q  <= RATE_LOW;
      dith_q  <= 1'b0;
      phase_q <= '0;
    end else if (boundary_i) begin
      rate_q  <= rate_nx_o;
      dith_q  <= dith_nx_o;
      phase_q <= phase_nx_o;
    end
  end
endmodule

// File: rtl/dpg_tri_shape.sv
// Triangular target offset (units of 1/M clock) and ascending flag for a
// given rate and sweep index.
module dpg_tri_shape
  import dpg_pkg::*;
#(
  parameter int DIV_LOW  = 16,
  parameter int DIV_HIGH = 8,
  parameter int CYC_LOW  = 25,
  parameter int CYC_HIGH = 50,
  parameter int SPREAD   = 8,
  parameter int PH_W     = 6,
  parameter int V_W      = 9
) (
  input  rate_e                  rate_i,
  input  logic                   dith_i,
  input  logic [PH_W-1:0]        phase_i,
  output logic signed [V_W-1:0]  value_o,
  output logic                   up_o
);
  localparam int AMP_LOW   = DIV_LOW / SPREAD;
  localparam int AMP_HIGH  = DIV_HIGH / SPREAD;
  localparam int PEAK_LOW  = AMP_LOW * CYC_LOW;
  localparam int PEAK_HIGH = AMP_HIGH * CYC_HIGH;

  int peak;
  int step;
  int x;
  int v;

  always_comb begin
    if (rate_i == RATE_HIGH) begin
      peak = PEAK_HIGH;
      step = 4 * AMP_HIGH;
    end else begin
      peak = PEAK_LOW;
      step = 4 * AMP_LOW;
    end
    x = step * int'(phase_i);
    if (x <= peak)          v = x;
    else if (x <= 3 * peak) v = 2 * peak - x;
    else                    v = x - 4 * peak;
    if (!dith_i) v = 0;
    value_o = V_W'(v);
    up_o    = dith_i && ((x < peak) || (x >= 3 * peak));
  end
endmodule

// File: rtl/dpg_frac_quant.sv
// Adds the target offset to the carried fraction and splits the sum into a
// whole-clock correction and a new fraction.
module dpg_frac_quant
  import dpg_pkg::*;
#(
  parameter int DIV_LOW  = 16,
  parameter int DIV_HIGH = 8,
  parameter int CYC_LOW  = 25,
  parameter int CYC_HIGH = 50,
  parameter int V_W      = 9,
  parameter int FR_W     = 6,
  parameter int LEN_W    = 5,
  parameter int QOFF     = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  boundary_i,
  input  logic                  restart_i,
  input  rate_e                 rate_i,
  input  logic signed [V_W-1:0] value_i,
  output logic [LEN_W-1:0]      len_nx_o
);
  logic [FR_W-1:0] carry_q;
  logic [FR_W-1:0] carry_nx;
  int m;
  int n;
  int cin;
  int s;
  int k;

  always_comb begin
    if (rate_i == RATE_HIGH) begin
      m = CYC_HIGH;
      n = DIV_HIGH;
    end else begin
      m = CYC_LOW;
      n = DIV_LOW;
    end
    cin = restart_i ? 0 : int'(carry_q);
    s   = cin + int'(value_i) + QOFF * m;
    k   = 0;
    for (int i = 1; i <= 2 * QOFF; i++) begin
      if (s >= i * m) k = i;
    end
    len_nx_o = LEN_W'(n + k - QOFF);
    carry_nx = FR_W'(s - k * m);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         carry_q <= '0;
    else if (boundary_i) carry_q <= carry_nx;
  end
endmodule

// File: rtl/dpg_period_cnt.sv
// Counts clocks within a period and loads the next length at the boundary.
module dpg_period_cnt #(
  parameter int LEN_W   = 5,
  parameter int DIV_LOW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] len_nx_i,
  input  logic             up_nx_i,
  output logic             boundary_o,
  output logic             start_o,
  output logic [LEN_W-1:0] len_o,
  output logic             up_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             up_q;

  assign boundary_o = (cnt_q == len_q - 1'b1);
  assign start_o    = (cnt_q == '0);
  assign len_o      = len_q;
  assign up_o       = up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= LEN_W'(DIV_LOW);
      up_q  <= 1'b0;
    end else if (boundary_o) begin
      cnt_q <= '0;
      len_q <= len_nx_i;
      up_q  <= up_nx_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dither_period_gen.sv
module dither_period_gen
  import dpg_pkg::*;
#(
  parameter int DIV_LOW  = 16,
  parameter int DIV_HIGH = 8,
  parameter int CYC_LOW  = 25,
  parameter int CYC_HIGH = 50,
  parameter int SPREAD   = 8,
  localparam int LEN_W   = $clog2(DIV_LOW + DIV_LOW / SPREAD + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fast_sel_i,
  input  logic             dither_en_i,
  input  logic             hop_en_i,
  output logic             period_start_o,
  output logic [LEN_W-1:0] period_len_o,
  output logic             dither_up_o
);
  localparam int CYC_MAX  = imax(CYC_LOW, CYC_HIGH);
  localparam int PH_W     = $clog2(CYC_MAX);
  localparam int FR_W     = $clog2(CYC_MAX);
  localparam int PEAK_MAX = imax((DIV_LOW / SPREAD) * CYC_LOW, (DIV_HIGH / SPREAD) * CYC_HIGH);
  localparam int V_W      = $clog2(4 * PEAK_MAX + 1) + 1;
  localparam int QOFF     = imax(DIV_LOW, DIV_HIGH) / SPREAD + 2;

  logic                  boundary;
  rate_e                 rate_nx;
  logic                  dith_nx;
  logic [PH_W-1:0]       phase_nx;
  logic                  restart;
  logic signed [V_W-1:0] value_nx;
  logic                  up_nx;
  logic [LEN_W-1:0]      len_nx;

  dpg_rate_ctrl #(
    .CYC_LOW (CYC_LOW),
    .CYC_HIGH(CYC_HIGH),
    .PH_W    (PH_W)
  ) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary),
    .fast_sel_i (fast_sel_i),
    .dither_en_i(dither_en_i),
    .hop_en_i   (hop_en_i),
    .rate_nx_o  (rate_nx),
    .dith_nx_o  (dith_nx),
    .phase_nx_o (phase_nx),
    .restart_o  (restart)
  );

  dpg_tri_shape #(
    .DIV_LOW (DIV_LOW),
    .DIV_HIGH(DIV_HIGH),
    .CYC_LOW (CYC_LOW),
    .CYC_HIGH(CYC_HIGH),
    .SPREAD  (SPREAD),
    .PH_W    (PH_W),
    .V_W     (V_W)
  ) u_tri (
    .rate_i (rate_nx),
    .dith_i (dith_nx),
    .phase_i(phase_nx),
    .value_o(value_nx),
    .up_o   (up_nx)
  );

  dpg_frac_quant #(
    .DIV_LOW (DIV_LOW),
    .DIV_HIGH(DIV_HIGH),
    .CYC_LOW (CYC_LOW),
    .CYC_HIGH(CYC_HIGH),
    .V_W     (V_W),
    .FR_W    (FR_W),
    .LEN_W   (LEN_W),
    .QOFF    (QOFF)
  ) u_quant (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .boundary_i(boundary),
    .restart_i (restart),
    .rate_i    (rate_nx),
    .value_i   (value_nx),
    .len_nx_o  (len_nx)
  );

  dpg_period_cnt #(
    .LEN_W  (LEN_W),
    .DIV_LOW(DIV_LOW)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .len_nx_i  (len_nx),
    .up_nx_i   (up_nx),
    .boundary_o(boundary),
    .start_o   (period_start_o),
    .len_o     (period_len_o),
    .up_o      (dither_up_o)
  );
endmodule

// File: rtl/dpg_checker.sv
module dpg_checker #(
  parameter int DIV_LOW  = 16,
  parameter int DIV_HIGH = 8,
  parameter int SPREAD   = 8,
  parameter int LEN_W    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fast_sel_i,
  input logic             dither_en_i,
  input logic             hop_en_i,
  input logic             period_start_o,
  input logic [LEN_W-1:0] period_len_o,
  input logic             dither_up_o
);
  localparam int LO_MIN = DIV_LOW - DIV_LOW / SPREAD;
  localparam int LO_MAX = DIV_LOW + DIV_LOW / SPREAD;
  localparam int HI_MIN = DIV_HIGH - DIV_HIGH / SPREAD;
  localparam int HI_MAX = DIV_HIGH + DIV_HIGH / SPREAD;

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |=> !period_start_o);

  assert_len_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !period_start_o) |-> $stable(period_len_o));

  assert_len_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(period_len_o) >= LO_MIN) && (int'(period_len_o) <= LO_MAX)) ||
    ((int'(period_len_o) >= HI_MIN) && (int'(period_len_o) <= HI_MAX)));

  assert_plain_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && period_start_o && !$past(dither_en_i) && !$past(hop_en_i)) |->
    (int'(period_len_o) == ($past(fast_sel_i) ? DIV_HIGH : DIV_LOW)));

  assert_up_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && period_start_o && !$past(dither_en_i)) |-> !dither_up_o);
endmodule

bind dither_period_gen dpg_checker #(
  .DIV_LOW (DIV_LOW),
  .DIV_HIGH(DIV_HIGH),
  .SPREAD  (SPREAD),
  .LEN_W   (LEN_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fast_sel_i    (fast_sel_i),
  .dither_en_i   (dither_en_i),
  .hop_en_i      (hop_en_i),
  .period_start_o(period_start_o),
  .period_len_o  (period_len_o),
  .dither_up_o   (dither_up_o)
);

// File: tb/dither_period_gen_tb_top.sv
`timescale 1ns/1ps
module dither_period_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs = 1'b0;
  logic       de = 1'b0;
  logic       he = 1'b0;
  logic       start;
  logic [4:0] len;
  logic       up;

  always #2 clk = ~clk;

  dither_period_gen dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .fast_sel_i    (fs),
    .dither_en_i   (de),
    .hop_en_i      (he),
    .period_start_o(start),
    .period_len_o  (len),
    .dither_up_o   (up)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference built from the requirement formulas
  function automatic int nom(input int rt);  return rt ? 8 : 16; endfunction
  function automatic int cyc(input int rt);  return rt ? 50 : 25; endfunction
  function automatic int peak(input int rt); return (nom(rt) / 8) * cyc(rt); endfunction
  function automatic int stp(input int rt);  return 4 * (nom(rt) / 8); endfunction

  int m_rate, m_dith, m_phase, m_carry, exp_len, exp_up;

  task automatic model_reset();
    m_rate = 0; m_dith = 0; m_phase = 0; m_carry = 0; exp_len = 16; exp_up = 0;
  endtask

  task automatic model_step(input bit f, input bit d, input bit h);
    bit last, rs;
    int nr, pn, cin, x, v, r, mm, q, p;
    last = (m_phase == cyc(m_rate) - 1);
    if (h) nr = last ? 1 - m_rate : m_rate;
    else   nr = f;
    rs  = (nr != m_rate) || (int'(d) != m_dith);
    pn  = (rs || last) ? 0 : m_phase + 1;
    cin = rs ? 0 : m_carry;
    x   = stp(nr) * pn;
    p   = peak(nr);
    if (x <= p)          v = x;
    else if (x <= 3 * p) v = 2 * p - x;
    else                 v = x - 4 * p;
    if (!d) v = 0;
    r  = cin + v;
    mm = cyc(nr);
    if (r >= 0) q = r / mm;
    else        q = -((-r + mm - 1) / mm);
    m_carry = r - q * mm;
    exp_len = nom(nr) + q;
    exp_up  = (d && ((x < p) || (x >= 3 * p))) ? 1 : 0;
    m_rate = nr; m_dith = d; m_phase = pn;
  endtask

  // Called at the falling edge where a start is seen; returns at the next one.
  task automatic one_period(input string req, input int mid_at, input bit mid_fs,
                            output int l, output int d, output bit u);
    int e;
    e = exp_len;
    l = int'(len);
    u = up;
    chk(start == 1'b1, req, "start pulse present", int'(start), 1);
    chk(l == e, req, "period length", l, e);
    chk(int'(u) == exp_up, req, "dither_up", int'(u), exp_up);
    d = 1;
    forever begin
      @(negedge clk);
      if (start) break;
      d++;
      if (d == mid_at) fs = mid_fs;
      if (d > 64) begin
        chk(1'b0, req, "start timeout", d, e);
        break;
      end
    end
    chk(d == e, req, "measured period", d, e);
    model_step(fs, de, he);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fs = 1'b0; de = 1'b0; he = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    chk(start == 1'b1, "R1", "start right after reset", int'(start), 1);
    chk(int'(len) == 16, "R1", "length after reset", int'(len), 16);
    chk(up == 1'b0, "R1", "dither_up after reset", int'(up), 0);
  endtask

  task automatic t_fixed_low();
    int l, d; bit u;
    for (int i = 0; i < 3; i++) begin
      one_period("R2", -1, 1'b0, l, d, u);
      chk(d == 16, "R2", "plain low period", d, 16);
    end
  endtask

  task automatic t_fixed_high();
    int l, d; bit u;
    fs = 1'b1;
    one_period("R7", -1, 1'b0, l, d, u);
    chk(d == 16, "R7", "period in progress keeps old rate", d, 16);
    for (int i = 0; i < 3; i++) begin
      one_period("R2", -1, 1'b0, l, d, u);
      chk(d == 8, "R2", "plain high period", d, 8);
    end
  endtask

  task automatic t_mid_change();
    int l, d; bit u;
    one_period("R7", 3, 1'b0, l, d, u);
    chk(d == 8, "R7", "mid-period select change ignored", d, 8);
    one_period("R7", -1, 1'b0, l, d, u);
    chk(l == 16, "R7", "select applies next period", l, 16);
  endtask

  task automatic t_dither(input bit rt);
    int l, d, sum, mn, mx, ups, eu, n, mm;
    bit u;
    string tag;
    n = nom(rt); mm = cyc(rt);
    fs = rt; de = 1'b1; he = 1'b0;
    one_period("R7", -1, 1'b0, l, d, u);
    sum = 0; mn = 99; mx = 0; ups = 0;
    for (int i = 0; i < mm; i++) begin
      one_period("R5", -1, 1'b0, l, d, u);
      if (i == 0) chk(l == n, "R5", "sweep starts at nominal", l, n);
      sum += d;
      if (d < mn) mn = d;
      if (d > mx) mx = d;
      if (u) ups++;
    end
    eu = 0;
    for (int p = 0; p < mm; p++)
      if ((stp(rt) * p < peak(rt)) || (stp(rt) * p >= 3 * peak(rt))) eu++;
    tag = rt ? "high" : "low";
    chk(mn >= n - n / 8, "R3", {"min length ", tag}, mn, n - n / 8);
    chk(mx <= n + n / 8, "R3", {"max length ", tag}, mx, n + n / 8);
    chk(sum == mm * n, "R4", {"sweep total ", tag}, sum, mm * n);
    chk(ups == eu, "R6", {"ascending count ", tag}, ups, eu);
  endtask

  task automatic t_hop();
    int l, d, cls, prev, run, changes;
    bit u;
    he = 1'b1;
    prev = -1; run = 0; changes = 0;
    for (int i = 0; i < 200; i++) begin
      cls = (int'(len) <= 9) ? 1 : 0;
      if (prev >= 0 && cls != prev) begin
        chk(run == cyc(prev), "R8", "periods per hopped sweep", run, cyc(prev));
        changes++;
        run = 0;
      end
      prev = cls;
      run++;
      fs = ~fs;
      one_period("R8", -1, 1'b0, l, d, u);
    end
    chk(changes == 4, "R8", "rate toggles over 200 periods", changes, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fixed_low();
    t_fixed_high();
    t_mid_change();
    t_dither(1'b0);
    t_dither(1'b1);
    t_hop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule